// File: doc/BRIEF.md
# Ladder Readout Sequencer

This block runs the readout of one detector ladder. Several pixel chips hang on one shared 32-line data bus. Each chip has its own select line, and the block raises exactly one select at a time. A selected chip shifts out one row of 32 binary hit bits per readout clock. A full chip takes a fixed number of rows, 256 by default. The chips themselves add no framing, so the sequencer builds a complete event around their raw words. It sends a header word, then every row of every chip in chip order, then a trailer word. The trailer carries a word count and a parity digest.

A single start pulse launches one event. Words leave on a valid/ready stream that carries three markers: start of event, end of chip and end of event. The readout clock enable rises only when the downstream side can accept a word, so back-pressure holds the chips in place and no bus row is ever lost. Between two chips the sequencer spends one cycle with no select raised, so the bus drivers of the two chips never overlap. Start pulses that arrive during a readout are counted and served one after another.

Top module: `ladder_readout_seq`

## Requirements
- R1: After reset, all chip selects, the readout clock enable and the stream valid are low, and the event counter is zero.
- R2: Each event opens with a header word whose upper half is the tag 0xA5C3 and whose lower half is the event counter. The counter starts at 0 and rises by one per finished event. The header is the only word with the start-of-event marker set.
- R3: At most one chip select is high in any cycle. Chips are read in index order 0 to N_CHIPS-1. While chip k is read, only select bit k is high, and each bus word appears unchanged as a stream data word.
- R4: The readout clock enable is high only when a chip is selected and downstream ready is high. While ready is low, the row position and the select do not change. Every row of every chip appears exactly once per event.
- R5: The select moves away from a chip only after that chip's last row has been transferred. Between two chips there is exactly one cycle with no select and no valid word.
- R6: The end-of-chip marker is set only on the data word of each chip's last row, which is row ROWS-1.
- R7: The last word of an event is a trailer with the end-of-event marker set. Its upper half is the number of data words in the event. Its lower half is the XOR of the two halves of the XOR of all data words in the event.
- R8: A start pulse that arrives while an event is in progress is queued, up to 15 deep, and produces a full event after the current one. With no start pending, the block stays idle.
- R9: While a header or trailer word is offered and ready is low, valid stays high and the word stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to read an event |
| bus_data_i | input | BUS_W | Shared ladder data bus, one row of the selected chip |
| chip_sel_o | output | N_CHIPS | One select line per chip, at most one high |
| rd_en_o | output | 1 | Readout clock enable; the selected chip advances one row when high |
| m_valid_o | output | 1 | Stream word valid |
| m_ready_i | input | 1 | Downstream can accept a word |
| m_data_o | output | BUS_W | Stream word: header, bus row or trailer |
| m_sof_o | output | 1 | Marks the header word |
| m_eoc_o | output | 1 | Marks the last row word of a chip |
| m_eoe_o | output | 1 | Marks the trailer word |

## Verification
Several properties are checked on every cycle, next to the logic that drives them. At most one select is raised. The enable rises only with ready and a select. The row position and select stay frozen during a stall. A chip is never replaced by another without an empty cycle, and a select falls only right after an end-of-chip transfer. Framing words are held while stalled. Other properties need whole scenarios from the bench and a model of the chips: the exact order and content of words under random back-pressure, the single idle cycle at each chip change, the trailer count and parity, the header numbering, and the serving of start pulses that queue up behind a running event.

// File: rtl/ladder_rd_pkg.sv
package ladder_rd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_READ,
      ST_GAP,
      ST_TRL
   } seq_state_t;

   function automatic int unsigned clog2_min1(input int unsigned v);
      return (v <= 1) ? 1 : $clog2(v);
   endfunction

endpackage

// File: rtl/ladder_chip_sel.sv
module ladder_chip_sel #(
   parameter int unsigned N_CHIPS = 8,
   parameter int unsigned IDX_W   = 3
) (
   input  logic               en_i,
   input  logic [IDX_W-1:0]   idx_i,
   output logic [N_CHIPS-1:0] sel_o
);
   for (genvar g = 0; g < N_CHIPS; g++) begin : g_sel
      assign sel_o[g] = en_i && (idx_i == IDX_W'(g));
   end
endmodule

// File: rtl/ladder_frame_acc.sv
module ladder_frame_acc #(
   parameter int unsigned W = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr_i,
   input  logic           beat_i,
   input  logic [W-1:0]   data_i,
   output logic [W/2-1:0] count_o,
   output logic [W/2-1:0] fold_o
);
   localparam int unsigned H = W / 2;

   logic [W-1:0] xacc_q;
   logic [H-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         xacc_q <= '0;
         cnt_q  <= '0;
      end else if (beat_i) begin
         xacc_q <= xacc_q ^ data_i;
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   for (genvar b = 0; b < H; b++) begin : g_fold
      assign fold_o[b] = xacc_q[b] ^ xacc_q[b+H];
   end

   assign count_o = cnt_q;
endmodule

// File: rtl/ladder_start_queue.sv
module ladder_start_queue #(
   parameter int unsigned PEND_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic push_i,
   input  logic pop_i,
   output logic pend_o
);
   logic [PEND_W-1:0] level_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level_q <= '0;
      end else if (push_i && !pop_i) begin
         if (level_q != '1) level_q <= level_q + 1'b1;
      end else if (pop_i && !push_i) begin
         level_q <= level_q - 1'b1;
      end
   end

   assign pend_o = (level_q != '0);

   AST_POP_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> (level_q != '0)); // R8
endmodule

// File: rtl/ladder_readout_seq.sv
module ladder_readout_seq
   import ladder_rd_pkg::*;
#(
   parameter int unsigned N_CHIPS = 8,
   parameter int unsigned ROWS    = 256,
   parameter int unsigned BUS_W   = 32,
   parameter int unsigned PEND_W  = 4,
   parameter int unsigned HDR_TAG = 32'h0000_A5C3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [BUS_W-1:0]   bus_data_i,
   output logic [N_CHIPS-1:0] chip_sel_o,
   output logic               rd_en_o,
   output logic               m_valid_o,
   input  logic               m_ready_i,
   output logic [BUS_W-1:0]   m_data_o,
   output logic               m_sof_o,
   output logic               m_eoc_o,
   output logic               m_eoe_o
);
   localparam int unsigned IDX_W  = clog2_min1(N_CHIPS);
   localparam int unsigned ROW_W  = clog2_min1(ROWS);
   localparam int unsigned HALF_W = BUS_W / 2;
   localparam int unsigned WORDS  = N_CHIPS * ROWS;
   localparam logic [IDX_W-1:0] LAST_CHIP = IDX_W'(N_CHIPS - 1);
   localparam logic [ROW_W-1:0] LAST_ROW  = ROW_W'(ROWS - 1);

   if (BUS_W < 4 || (BUS_W % 2) != 0) begin : g_bad_bus
      $error("BUS_W must be even and at least 4");
   end
   if (N_CHIPS < 1 || ROWS < 2) begin : g_bad_geom
      $error("need at least one chip and two rows");
   end
   if ((WORDS >> HALF_W) != 0) begin : g_bad_count
      $error("word count does not fit the trailer count field");
   end
   if (PEND_W < 1) begin : g_bad_pend
      $error("PEND_W must be at least 1");
   end

   seq_state_t        state_q, state_d;
   logic [ROW_W-1:0]  row_q, row_d;
   logic [IDX_W-1:0]  chip_q, chip_d;
   logic [HALF_W-1:0] evt_q;
   logic              beat, pend, push, pop;
   logic [HALF_W-1:0] acc_cnt, acc_fold;

   assign beat = m_valid_o && m_ready_i;
   assign pop  = (state_q == ST_IDLE) && pend;
   assign push = start_i && !((state_q == ST_IDLE) && !pend);

   ladder_start_queue #(.PEND_W(PEND_W)) u_queue (
      .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop), .pend_o(pend));

   ladder_chip_sel #(.N_CHIPS(N_CHIPS), .IDX_W(IDX_W)) u_sel (
      .en_i(state_q == ST_READ), .idx_i(chip_q), .sel_o(chip_sel_o));

   ladder_frame_acc #(.W(BUS_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr_i(state_q == ST_HDR),
      .beat_i(beat && (state_q == ST_READ)), .data_i(bus_data_i),
      .count_o(acc_cnt), .fold_o(acc_fold));

   always_comb begin
      state_d = state_q;
      row_d   = row_q;
      chip_d  = chip_q;
      unique case (state_q)
         ST_IDLE: if (start_i || pend) state_d = ST_HDR;
         ST_HDR: if (beat) begin
            state_d = ST_READ;
            row_d   = '0;
            chip_d  = '0;
         end
         ST_READ: if (beat) begin
            if (row_q == LAST_ROW) begin
               row_d = '0;
               if (chip_q == LAST_CHIP) begin
                  state_d = ST_TRL;
               end else begin
                  state_d = ST_GAP;
                  chip_d  = chip_q + 1'b1;
               end
            end else begin
               row_d = row_q + 1'b1;
            end
         end
         ST_GAP:  state_d = ST_READ;
         ST_TRL:  if (beat) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         row_q   <= '0;
         chip_q  <= '0;
         evt_q   <= '0;
      end else begin
         state_q <= state_d;
         row_q   <= row_d;
         chip_q  <= chip_d;
         if (state_q == ST_TRL && beat) evt_q <= evt_q + 1'b1;
      end
   end

   always_comb begin
      unique case (state_q)
         ST_HDR:  m_data_o = {HALF_W'(HDR_TAG), evt_q};
         ST_READ: m_data_o = bus_data_i;
         ST_TRL:  m_data_o = {acc_cnt, acc_fold};
         default: m_data_o = '0;
      endcase
   end

   assign m_valid_o = (state_q == ST_HDR) || (state_q == ST_READ) || (state_q == ST_TRL);
   assign rd_en_o   = (state_q == ST_READ) && m_ready_i;
   assign m_sof_o   = (state_q == ST_HDR);
   assign m_eoc_o   = (state_q == ST_READ) && (row_q == LAST_ROW);
   assign m_eoe_o   = (state_q == ST_TRL);

   AST_SEL_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chip_sel_o)); // R3
   AST_EN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_o |-> (m_ready_i && (chip_sel_o != '0))); // R4
   AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_READ && !m_ready_i) |=> ($stable(row_q) && $stable(chip_sel_o))); // R4
   AST_NO_DIRECT_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(chip_sel_o) != '0) && (chip_sel_o != '0)) |-> (chip_sel_o == $past(chip_sel_o))); // R5
   AST_DESELECT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(chip_sel_o) != '0) && (chip_sel_o == '0)) |-> $past(m_eoc_o && m_ready_i)); // R5
   AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid_o && !m_ready_i && state_q != ST_READ) |=> (m_valid_o && $stable(m_data_o))); // R9
endmodule

// File: tb/ladder_readout_seq_tb_top.sv
`timescale 1ns/100ps
module ladder_readout_seq_tb_top;
   localparam int N   = 8;
   localparam int RWS = 256;
   localparam int NW  = N * RWS;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          ready = 1'b0;
   logic [31:0]   bus;
   logic [N-1:0]  sel;
   logic          rd_en, valid, sof, eoc, eoe;
   logic [31:0]   data;

   int n_vec = 0, n_bad = 0, cyc = 0;
   int rdy_mode = 0;        // 0 always ready, 1 random, 2 held low
   int pos = 0, ev = 0;
   int mrow = 0;
   int gstage = 0, gnext = 0;
   logic        hold_prev = 1'b0;
   logic [31:0] hold_data = '0;
   logic [31:0] xacc = '0;
   logic [31:0] salt [8];

   always #2.5 clk = ~clk;

   ladder_readout_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .bus_data_i(bus),
      .chip_sel_o(sel), .rd_en_o(rd_en), .m_valid_o(valid), .m_ready_i(ready),
      .m_data_o(data), .m_sof_o(sof), .m_eoc_o(eoc), .m_eoe_o(eoe));

   function automatic logic [31:0] row_word(int e, int c, int r);
      return salt[e % 8] ^ (32'(c) << 24) ^ (32'(r) << 8) ^ 32'(r * (c + 3));
   endfunction

   function automatic int sel_idx(logic [N-1:0] s);
      int k = 0;
      for (int i = 0; i < N; i++) if (s[i]) k = i;
      return k;
   endfunction

   // chip model: selected chip drives its current row, shifts on rd_en
   always_comb bus = (sel != '0) ? row_word(ev, sel_idx(sel), mrow) : 32'h0;
   always @(posedge clk) begin
      if (!rst_n) mrow <= 0;
      else if (rd_en) mrow <= (mrow == RWS - 1) ? 0 : mrow + 1;
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at pos %0d ev %0d", req, act, exp, pos, ev);
      end
   endtask

   // monitor at the falling edge
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (rd_en && !ready) chk("R4 enable without ready", 32'(rd_en), 32'h0);
         if (gstage == 2) begin
            chk("R5 next chip select", 32'(sel), 32'(1 << gnext));
            gstage = 0;
         end
         if (gstage == 1) begin
            chk("R5 gap cycle select", 32'(sel), 32'h0);
            chk("R5 gap cycle valid", 32'(valid), 32'h0);
            gstage = 2;
         end
         if (hold_prev) begin
            chk("R9 valid held", 32'(valid), 32'h1);
            chk("R9 word held", data, hold_data);
         end
         hold_prev = valid && !ready && (sel == '0);
         hold_data = data;
         if (valid && ready) begin
            if (pos == 0) begin
               chk("R2 header", data, {16'hA5C3, 16'(ev)});
               chk("R2 markers", {29'h0, sof, eoc, eoe}, 32'h4);
               xacc = '0;
               pos++;
            end else if (pos <= NW) begin
               automatic int k = pos - 1;
               automatic int c = k / RWS;
               automatic int r = k % RWS;
               automatic logic [31:0] w = row_word(ev, c, r);
               chk("R3 data word", data, w);
               chk("R3 chip select", 32'(sel), 32'(1 << c));
               chk("R6 markers", {29'h0, sof, eoc, eoe}, {30'h0, (r == RWS - 1), 1'b0});
               xacc ^= w;
               if (r == RWS - 1 && c != N - 1) begin
                  gstage = 1;
                  gnext = c + 1;
               end
               pos++;
            end else begin
               chk("R7 trailer", data, {16'(NW), xacc[31:16] ^ xacc[15:0]});
               chk("R7 markers", {29'h0, sof, eoc, eoe}, 32'h1);
               pos = 0;
               ev++;
            end
         end
      end
   end

   initial begin : ready_drv
      forever begin
         @(posedge clk); #1;
         case (rdy_mode)
            0: ready = 1'b1;
            1: ready = ($urandom % 100) < 60;
            default: ready = 1'b0;
         endcase
      end
   end

   task automatic pulse_start();
      @(posedge clk); #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
   endtask

   task automatic wait_events(int target);
      while (ev < target && cyc < 180000) @(negedge clk);
      if (ev < target) begin
         n_bad++; n_vec++;
         $display("FAIL watchdog: events actual=%0d expected=%0d", ev, target);
      end
   endtask

   initial begin : main
      void'($urandom(32'd4711));
      for (int i = 0; i < 8; i++) salt[i] = $urandom;
      repeat (4) @(posedge clk);
      #1;
      // R1: reset state
      chk("R1 selects", 32'(sel), 32'h0);
      chk("R1 enable", 32'(rd_en), 32'h0);
      chk("R1 valid", 32'(valid), 32'h0);
      rst_n = 1'b1;
      repeat (3) @(posedge clk);
      #1 chk("R8 idle without start", 32'(valid), 32'h0);

      // event 0: always ready
      rdy_mode = 0;
      pulse_start();
      wait_events(1);

      // event 1: header stall then random back-pressure (R9, R4)
      rdy_mode = 2;
      pulse_start();
      repeat (10) @(posedge clk);
      rdy_mode = 1;
      wait_events(2);

      // events 2..4: two starts queued during a running readout (R8)
      rdy_mode = 1;
      pulse_start();
      repeat (40) @(posedge clk);
      pulse_start();
      repeat (300) @(posedge clk);
      pulse_start();
      wait_events(5);
      repeat (20) @(posedge clk);
      #1;
      chk("R8 no extra event", 32'(ev), 32'd5);
      chk("R8 idle after queue drained", 32'(valid), 32'h0);
      chk("R1 selects low when idle", 32'(sel), 32'h0);

      // event 5: trailer stall under random ready, also checks counter value 5 (R2)
      pulse_start();
      wait_events(6);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule